// File: doc/BRIEF.md
# Idle Mode and Reset Controller

This block sits beside the CPU core of a small microcontroller and owns two things: the idle power-saving state and the qualification of the external reset pin. Software sets the idle-request bit through a one-bit register write port. From the next cycle the CPU clock enable is withdrawn, while the clock enable for the interrupt logic, timers and serial port stays high. An enabled, pending interrupt clears the idle bit by hardware and gives the CPU its clock enable back, so the interrupt can be serviced.

The raw reset pin passes through a two-flop synchronizer. A machine-cycle counter then measures how long the synchronized level stays high. Internal reset is raised only once the pin has been high across `MIN_MC` machine-cycle strobes. It stays raised while the pin remains high, and it is released on the first machine-cycle strobe that sees the pin low. Internal reset also cancels idle mode.

The reset qualifier has four states. `RQ_QUIET` means the pin is low and no measurement is running. `RQ_MEASURE` counts strobes while the pin is high. `RQ_ACTIVE` means internal reset is asserted and the pin is still high. `RQ_DRAIN` means internal reset is still asserted after the pin has fallen, while waiting for a strobe. Its transitions are:

- QUIET to MEASURE when the pin is seen high.
- MEASURE to QUIET when the pin falls before the count completes.
- MEASURE to ACTIVE when the count completes.
- ACTIVE to QUIET when the pin is low and a strobe arrives.
- ACTIVE to DRAIN when the pin is low and no strobe arrives.
- DRAIN to QUIET on a strobe.
- DRAIN to ACTIVE when the pin goes high again.

The power state machine has two states, `PW_RUN` and `PW_IDLE`. It moves RUN to IDLE on a write of 1 with no interrupt pending in that cycle. It moves IDLE to RUN on an interrupt. Internal reset forces it to RUN from either state.

Top module: `idle_rst_ctrl`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it rises, `cpu_clk_en`=1, `periph_clk_en`=1, `idle_flag`=0 and `core_rst`=0.
- R2: A write with `pwr_wr_en`=1 and `pwr_wr_idle`=1, with `irq_pending`=0 and `core_rst`=0, sets `idle_flag` to 1 and `cpu_clk_en` to 0 after that clock edge. `periph_clk_en` stays 1 throughout idle.
- R3: A write with `pwr_wr_idle`=0 while running leaves `idle_flag`=0 and `cpu_clk_en`=1.
- R4: In idle, `irq_pending`=1 at a clock edge clears `idle_flag` and sets `cpu_clk_en` to 1 after that edge.
- R5: A write of 1 in the same cycle as `irq_pending`=1 does not enter idle.
- R6: The reset pin is delayed by a two-flop synchronizer. If the raw pin is high for the W clock edges k to k+W-1, the synchronized level is high at edges k+2 to k+W+1. `core_rst` rises after the edge carrying the `MIN_MC`-th strobe (default 2) among those edges. If there are fewer such strobes, it never rises.
- R7: After the synchronized pin falls, `core_rst` stays 1 and falls after the first edge at or after k+W+2 that carries a strobe.
- R8: One edge after `core_rst` is 1, `idle_flag` is 0 and `cpu_clk_en` is 1. Idle-bit writes made while `core_rst`=1 have no effect.
- R9: `irq_pending` while running has no effect on `idle_flag` or `cpu_clk_en`.
- R10: Idle persists with no interrupt, including across a reset pulse too short to qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mc_strobe | input | 1 | One-cycle pulse marking each machine-cycle boundary |
| rst_pin | input | 1 | Raw external reset pin, active high, asynchronous |
| pwr_wr_en | input | 1 | Write strobe for the power-control register |
| pwr_wr_idle | input | 1 | Value written to the idle-request bit |
| irq_pending | input | 1 | An enabled interrupt is pending |
| idle_flag | output | 1 | Current value of the idle-request bit |
| cpu_clk_en | output | 1 | Clock enable for the CPU core |
| periph_clk_en | output | 1 | Clock enable for interrupt, timer and serial logic |
| core_rst | output | 1 | Qualified internal reset |

## Verification
Reset pulses of every width from 1 to 12 clock cycles are applied against a strobe with period 4, at four strobe phases. The expected number of cycles with `core_rst` high is computed from the strobe positions. This separates pulses that stay below the strobe count from those that just meet it, and it exposes an off-by-one in the synchronizer depth or in the release edge. The idle tests cover a plain write, a write of 0, a write colliding with an interrupt, an interrupt while running, and a wake-up by interrupt. Together they distinguish hardware clearing from the write path. Further tests apply a short pulse and a long pulse during idle, and an idle write during reset, to separate the reset paths from the interrupt path.

// File: rtl/idle_rst_pkg.sv
package idle_rst_pkg;

    typedef enum logic [1:0] {
        RQ_QUIET   = 2'd0,
        RQ_MEASURE = 2'd1,
        RQ_ACTIVE  = 2'd2,
        RQ_DRAIN   = 2'd3
    } rq_state_t;

    typedef enum logic {
        PW_RUN  = 1'b0,
        PW_IDLE = 1'b1
    } pw_state_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/reset_qualifier.sv
module reset_qualifier
    import idle_rst_pkg::*;
#(
    parameter int MIN_MC      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic mc_strobe,
    input  logic pin_raw,
    output logic rst_o
);
    localparam int CW = $clog2(MIN_MC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_MC - 1);

    logic      pin_s;
    rq_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   (pin_raw),
        .q_o   (pin_s)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= RQ_QUIET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RQ_QUIET: begin
                cnt_d = '0;
                if (pin_s) begin
                    if (mc_strobe && (MIN_MC <= 1)) begin
                        state_d = RQ_ACTIVE;
                    end else begin
                        state_d = RQ_MEASURE;
                        cnt_d   = mc_strobe ? CW'(1) : '0;
                    end
                end
            end
            RQ_MEASURE: begin
                if (!pin_s) begin
                    state_d = RQ_QUIET;
                    cnt_d   = '0;
                end else if (mc_strobe) begin
                    if (cnt_q == LAST) begin
                        state_d = RQ_ACTIVE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            RQ_ACTIVE: begin
                if (!pin_s) state_d = mc_strobe ? RQ_QUIET : RQ_DRAIN;
            end
            RQ_DRAIN: begin
                if (pin_s)          state_d = RQ_ACTIVE;
                else if (mc_strobe) state_d = RQ_QUIET;
            end
            default: state_d = RQ_QUIET;
        endcase
    end

    always_comb begin
        rst_o = (state_q == RQ_ACTIVE) || (state_q == RQ_DRAIN);
    end

    // R6: reset only rises on a strobe seen with the pin high
    a_r6_rise_on_strobe: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_o) |-> ($past(mc_strobe) && $past(pin_s)));

    // R7: reset only falls on a strobe seen with the pin low
    a_r7_fall_on_strobe: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_o) |-> ($past(mc_strobe) && !$past(pin_s)));

    // R6: a low synchronized pin outside reset never starts reset next cycle
    a_r6_low_pin_quiet: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_o && !pin_s) |=> !rst_o);
endmodule

// File: rtl/idle_ctrl.sv
module idle_ctrl
    import idle_rst_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic core_rst_i,
    input  logic wr_en_i,
    input  logic wr_idle_i,
    input  logic irq_i,
    output logic idle_o,
    output logic cpu_en_o
);
    pw_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= PW_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (core_rst_i) begin
            state_d = PW_RUN;
        end else begin
            unique case (state_q)
                PW_RUN:  if (wr_en_i && wr_idle_i && !irq_i) state_d = PW_IDLE;
                PW_IDLE: if (irq_i) state_d = PW_RUN;
                default: state_d = PW_RUN;
            endcase
        end
    end

    always_comb begin
        idle_o   = (state_q == PW_IDLE);
        cpu_en_o = (state_q == PW_RUN);
    end

    // R2: accepted idle write enters idle
    a_r2_enter_idle: assert property (@(posedge clk) disable iff (!por_n)
        (!idle_o && wr_en_i && wr_idle_i && !irq_i && !core_rst_i) |=> idle_o);

    // R4: interrupt during idle wakes the CPU
    a_r4_irq_wakes: assert property (@(posedge clk) disable iff (!por_n)
        (idle_o && irq_i) |=> (!idle_o && cpu_en_o));

    // R5 and R9: an interrupt while running keeps the CPU running
    a_r5_irq_blocks_entry: assert property (@(posedge clk) disable iff (!por_n)
        (!idle_o && irq_i) |=> !idle_o);

    // R8: internal reset cancels idle
    a_r8_rst_clears_idle: assert property (@(posedge clk) disable iff (!por_n)
        core_rst_i |=> (!idle_o && cpu_en_o));
endmodule

// File: rtl/idle_rst_ctrl.sv
module idle_rst_ctrl #(
    parameter int MIN_MC      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic mc_strobe,
    input  logic rst_pin,
    input  logic pwr_wr_en,
    input  logic pwr_wr_idle,
    input  logic irq_pending,
    output logic idle_flag,
    output logic cpu_clk_en,
    output logic periph_clk_en,
    output logic core_rst
);
    logic rst_int;

    reset_qualifier #(.MIN_MC(MIN_MC), .SYNC_STAGES(SYNC_STAGES)) u_rq (
        .clk       (clk),
        .por_n     (por_n),
        .mc_strobe (mc_strobe),
        .pin_raw   (rst_pin),
        .rst_o     (rst_int)
    );

    idle_ctrl u_idle (
        .clk        (clk),
        .por_n      (por_n),
        .core_rst_i (rst_int),
        .wr_en_i    (pwr_wr_en),
        .wr_idle_i  (pwr_wr_idle),
        .irq_i      (irq_pending),
        .idle_o     (idle_flag),
        .cpu_en_o   (cpu_clk_en)
    );

    assign core_rst      = rst_int;
    assign periph_clk_en = 1'b1;

    // R2: CPU enable and idle bit are never both active
    a_r2_enable_exclusive: assert property (@(posedge clk) disable iff (!por_n)
        !(idle_flag && cpu_clk_en));
endmodule

// File: tb/idle_rst_ctrl_tb.sv
module idle_rst_ctrl_tb;
    localparam int P      = 4;
    localparam int MIN_MC = 2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic mc_strobe = 1'b0;
    logic rst_pin = 1'b0;
    logic pwr_wr_en = 1'b0;
    logic pwr_wr_idle = 1'b0;
    logic irq_pending = 1'b0;
    logic idle_flag, cpu_clk_en, periph_clk_en, core_rst;

    int checks = 0;
    int fails = 0;
    int edges = 0;
    int wd = 0;

    always #5 clk = ~clk;

    idle_rst_ctrl #(.MIN_MC(MIN_MC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .por_n(por_n), .mc_strobe(mc_strobe), .rst_pin(rst_pin),
        .pwr_wr_en(pwr_wr_en), .pwr_wr_idle(pwr_wr_idle), .irq_pending(irq_pending),
        .idle_flag(idle_flag), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .core_rst(core_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic pin, input logic wr, input logic wdat, input logic irq);
        rst_pin     = pin;
        pwr_wr_en   = wr;
        pwr_wr_idle = wdat;
        irq_pending = irq;
        mc_strobe   = ((edges + 1) % P == 0);
        @(posedge clk);
        edges++;
        @(negedge clk);
    endtask

    function automatic int exp_hi(input int k, input int w);
        int n = 0;
        int rise = -1;
        int fall;
        for (int j = k + 2; j <= k + w + 1; j++) begin
            if (j % P == 0) begin
                n++;
                if (n == MIN_MC) rise = j;
            end
        end
        if (rise < 0) return 0;
        fall = k + w + 2;
        while (fall % P != 0) fall++;
        return fall - rise;
    endfunction

    task automatic pulse(input int w, output int hi);
        hi = 0;
        for (int i = 0; i < w; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0);
            if (core_rst) hi++;
        end
        for (int i = 0; i < 16; i++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b0);
            if (core_rst) hi++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=0", wd);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int hi;
        int k;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
        // R1: state held during power-on reset
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 idle_flag", idle_flag, 0);
        chk("R1 core_rst", core_rst, 0);
        chk("R1 periph_clk_en", periph_clk_en, 1);
        por_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 idle_flag after release", idle_flag, 0);
        chk("R1 cpu_clk_en after release", cpu_clk_en, 1);

        // R3: writing 0 keeps running
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 idle_flag", idle_flag, 0);
        chk("R3 cpu_clk_en", cpu_clk_en, 1);

        // R9: interrupt while running
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 idle_flag", idle_flag, 0);
        chk("R9 cpu_clk_en", cpu_clk_en, 1);

        // R5: write colliding with interrupt
        cyc(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R5 idle_flag", idle_flag, 0);
        chk("R5 cpu_clk_en", cpu_clk_en, 1);

        // R2: enter idle
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R2 idle_flag", idle_flag, 1);
        chk("R2 cpu_clk_en", cpu_clk_en, 0);
        chk("R2 periph_clk_en", periph_clk_en, 1);

        // R10: idle persists without interrupt
        for (int i = 0; i < 9; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 idle held", idle_flag, 1);
        chk("R10 periph_clk_en", periph_clk_en, 1);

        // R4: interrupt wakes
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4 idle_flag", idle_flag, 0);
        chk("R4 cpu_clk_en", cpu_clk_en, 1);

        // R6 and R7: sweep pulse widths and strobe phases
        for (int ph = 0; ph < P; ph++) begin
            for (int w = 1; w <= 12; w++) begin
                for (int p = 0; p <= ph; p++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
                k = edges + 1;
                pulse(w, hi);
                chk($sformatf("R6/R7 width %0d start %0d reset cycles", w, k), hi, exp_hi(k, w));
                chk($sformatf("R7 width %0d released", w), core_rst, 0);
            end
        end

        // R10: short pulse in idle does not wake
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10 idle entered", idle_flag, 1);
        while ((edges + 1) % P != 1) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        k = edges + 1;
        pulse(2, hi);
        chk("R10 short pulse no reset", hi, exp_hi(k, 2));
        chk("R10 idle survives short pulse", idle_flag, 1);

        // R8: long pulse ends idle, write during reset ignored
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 core_rst asserted", core_rst, 1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 idle cleared", idle_flag, 0);
        chk("R8 cpu_clk_en", cpu_clk_en, 1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R8 write during reset", idle_flag, 0);
        chk("R8 cpu_clk_en during write", cpu_clk_en, 1);
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 released after long pulse", core_rst, 0);
        chk("R8 idle still clear", idle_flag, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule